// File: doc/BRIEF.md
# UART Receive Ring-Buffer DMA Engine

This block turns a serial receive line into bytes and stores each byte in a circular region of on-chip RAM. The CPU is not involved in the transfer. A baud tick input marks every bit period. On each tick the deserializer samples an 8-N-1 frame, least significant bit first, with an optional ninth data bit. Each received byte goes out on a synchronous RAM write port at the buffer base address plus a running offset. The offset wraps inside a power-of-two loop whose length a 3-bit code selects.

The block keeps a live count of unread bytes. Software consumes data by writing a release amount, and the block subtracts it from the count. When a byte arrives while the buffer is already full of unread data, the block raises an overflow event. Software sets the block up in this order: choose the transfer mode, load the base address, enable the block, then write the kick register. After that it either polls the count or waits for the interrupts.

Register map (3-bit address, 8-bit data):

- Writes:
  - 0: control.
  - 1: base high byte. The value is only staged.
  - 2: base low byte. This write commits the whole base.
  - 3: release amount.
  - 4: kick.
- Reads:
  - 0: control.
  - 1: staged high byte.
  - 2: low byte of the active base.
  - 3: last received byte.
  - 4: unread count, high byte.
  - 5: unread count, low byte.
  - 6: status.
  - 7: reads as zero.

Control bits:

- bit 0: enable.
- bit 1: ring mode.
- bit 2: ninth-bit mode.
- bits 5:3: loop code.
- bit 6: receive interrupt enable.
- bit 7: overflow interrupt enable.

Status bits:

- bit 0: framing error.
- bit 1: ninth bit.
- bit 2: sticky overflow.
- bit 3: armed.

Top module: `uart_rx_ring_dma`

## Requirements
- R1: After reset the unread count, the status byte, ram_we, irq_rx and irq_ovf are all zero.
- R2: A frame starts on a tick that samples rxd low while the deserializer is idle. The following ticks sample the data bits, least significant bit first: 8 bits, or 9 when control bit 2 is set. One more tick samples the stop bit. The low 8 data bits appear at read address 3 and the ninth data bit appears in status bit 1.
- R3: Status bit 0 is 1 when the stop bit of the most recent frame was 0, and 0 when it was 1.
- R4: In ring mode each byte is written to base + offset. The offset advances by one per byte and wraps modulo the loop length. Loop codes 000 to 110 give 16, 32, 64, 128, 256, 512 and 1024 bytes, and code 111 acts as 1024.
- R5: Every byte written to RAM raises the unread count by one. The count reads as a high byte at address 4 and a low byte at address 5.
- R6: A write to address 3 subtracts its data from the unread count, and the count clamps at zero. A release and a byte landing in the same cycle combine into one net update.
- R7: A byte arriving while the count equals the loop length is still written to RAM. The count stays at the loop length, status bit 2 sets and stays set, and irq_ovf pulses for one cycle if control bit 7 is set.
- R8: A write to address 1 only stages the high byte. The active base changes only on the next write to address 2.
- R9: A write to address 4 arms ring transfers and clears the offset, the unread count and the overflow flag. The armed state shows in status bit 3.
- R10: irq_rx pulses for one cycle per received byte when control bit 6 is set. It stays low when bit 6 is clear. With control bit 1 clear, bytes still reach address 3 and raise irq_rx, but nothing is written to RAM.
- R11: Clearing enable or ring mode disarms the block. RAM writes resume only after a new kick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One pulse per bit period |
| rxd | input | 1 | Serial receive line, idle high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 16 | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| irq_rx | output | 1 | Per-byte receive interrupt pulse |
| irq_ovf | output | 1 | Overflow interrupt pulse |

## Verification
The hardest case to reach is a release write that lands in exactly the cycle in which a received byte updates the count. The bench holds the bit timing itself: it issues every baud tick from its frame task. Right after the stop-bit tick, it drives the release write so that both updates meet at one clock edge. The overflow corner needs the ring filled to exactly its loop length first. So the bench runs the 16-byte loop through a wrap and then sends one byte more.

// File: rtl/urx_pkg.sv
package urx_pkg;

  // write-side register addresses
  localparam logic [2:0] WA_CTRL    = 3'd0;
  localparam logic [2:0] WA_BASE_HI = 3'd1;
  localparam logic [2:0] WA_BASE_LO = 3'd2;
  localparam logic [2:0] WA_RELEASE = 3'd3;
  localparam logic [2:0] WA_KICK    = 3'd4;

  // read-side register addresses
  localparam logic [2:0] RA_CTRL    = 3'd0;
  localparam logic [2:0] RA_HI_STG  = 3'd1;
  localparam logic [2:0] RA_BASE_LO = 3'd2;
  localparam logic [2:0] RA_LAST    = 3'd3;
  localparam logic [2:0] RA_CNT_HI  = 3'd4;
  localparam logic [2:0] RA_CNT_LO  = 3'd5;
  localparam logic [2:0] RA_STATUS  = 3'd6;

  typedef struct packed {
    logic       ovf_ie;
    logic       rx_ie;
    logic [2:0] loop_code;
    logic       ninth_en;
    logic       ring_mode;
    logic       enable;
  } ctrl_t;

  typedef enum logic [1:0] {DS_IDLE, DS_DATA, DS_STOP} ds_state_t;

  // ring length in bytes for a loop code; the top code behaves as the largest
  function automatic logic [15:0] ring_len(input logic [2:0] code);
    ring_len = (code == 3'b111) ? 16'd1024 : (16'd16 << code);
  endfunction

endpackage

// File: rtl/urx_deser.sv
module urx_deser
  import urx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic          rxd,
  input  logic          ninth_en,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          bit9,
  output logic          frame_err
);

  localparam int BC_W = $clog2(DW + 2);

  ds_state_t     st_q, st_n;
  logic [BC_W-1:0] bc_q, bc_n;
  logic [DW:0]   sh_q, sh_n;
  logic          nine_q, nine_n;
  logic          done_q, done_n;
  logic [DW-1:0] data_q, data_n;
  logic          b9_q, b9_n;
  logic          fe_q, fe_n;

  always_comb begin
    st_n   = st_q;
    bc_n   = bc_q;
    sh_n   = sh_q;
    nine_n = nine_q;
    done_n = 1'b0;
    data_n = data_q;
    b9_n   = b9_q;
    fe_n   = fe_q;
    if (!en) begin
      st_n = DS_IDLE;
    end else if (tick) begin
      unique case (st_q)
        DS_IDLE: if (!rxd) begin
          st_n   = DS_DATA;
          bc_n   = '0;
          nine_n = ninth_en;
        end
        DS_DATA: begin
          sh_n = {rxd, sh_q[DW:1]};
          bc_n = bc_q + 1'b1;
          if (bc_q == (nine_q ? BC_W'(DW) : BC_W'(DW - 1))) st_n = DS_STOP;
        end
        DS_STOP: begin
          st_n   = DS_IDLE;
          done_n = 1'b1;
          fe_n   = ~rxd;
          data_n = nine_q ? sh_q[DW-1:0] : sh_q[DW:1];
          b9_n   = nine_q ? sh_q[DW] : 1'b0;
        end
        default: st_n = DS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= DS_IDLE;
      bc_q   <= '0;
      sh_q   <= '0;
      nine_q <= 1'b0;
      done_q <= 1'b0;
      data_q <= '0;
      b9_q   <= 1'b0;
      fe_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      bc_q   <= bc_n;
      sh_q   <= sh_n;
      nine_q <= nine_n;
      done_q <= done_n;
      data_q <= data_n;
      b9_q   <= b9_n;
      fe_q   <= fe_n;
    end
  end

  assign done      = done_q;
  assign data      = data_q;
  assign bit9      = b9_q;
  assign frame_err = fe_q;

  // R2: a frame spans at least ten ticks, so completion is a single-cycle pulse
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/urx_regs.sv
module urx_regs
  import urx_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [2:0]        rd_addr,
  output logic [7:0]        rd_data,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [7:0]        last_byte,
  input  logic [7:0]        status,
  output ctrl_t             ctrl,
  output logic [ADDR_W-1:0] base,
  output logic              rel_stb,
  output logic [7:0]        rel_val,
  output logic              kick_stb
);

  localparam int HI_W = ADDR_W - 8;

  ctrl_t             ctrl_q, ctrl_n;
  logic [HI_W-1:0]   hi_q, hi_n;
  logic [ADDR_W-1:0] base_q, base_n;
  logic [15:0]       cnt16;

  always_comb begin
    ctrl_n = ctrl_q;
    hi_n   = hi_q;
    base_n = base_q;
    if (wr_en) begin
      unique case (wr_addr)
        WA_CTRL:    ctrl_n = ctrl_t'(wr_data);
        WA_BASE_HI: hi_n   = HI_W'(wr_data);
        WA_BASE_LO: base_n = {hi_q, wr_data};
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      hi_q   <= '0;
      base_q <= '0;
    end else begin
      ctrl_q <= ctrl_n;
      hi_q   <= hi_n;
      base_q <= base_n;
    end
  end

  assign ctrl     = ctrl_q;
  assign base     = base_q;
  assign rel_stb  = wr_en && (wr_addr == WA_RELEASE);
  assign rel_val  = wr_data;
  assign kick_stb = wr_en && (wr_addr == WA_KICK);
  assign cnt16    = 16'(cnt);

  always_comb begin
    unique case (rd_addr)
      RA_CTRL:    rd_data = ctrl_q;
      RA_HI_STG:  rd_data = 8'(hi_q);
      RA_BASE_LO: rd_data = base_q[7:0];
      RA_LAST:    rd_data = last_byte;
      RA_CNT_HI:  rd_data = cnt16[15:8];
      RA_CNT_LO:  rd_data = cnt16[7:0];
      RA_STATUS:  rd_data = status;
      default:    rd_data = 8'h00;
    endcase
  end

  // R8: the active base moves only on a low-byte write
  a_r8_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == WA_BASE_LO) |=> $stable(base_q));

endmodule

// File: rtl/urx_ring.sv
module urx_ring
  import urx_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_dma,
  input  logic              kick,
  input  logic              byte_stb,
  input  logic [7:0]        byte_in,
  input  logic [2:0]        loop_code,
  input  logic [ADDR_W-1:0] base,
  input  logic              rel_stb,
  input  logic [7:0]        rel_val,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic [CNT_W-1:0]  count,
  output logic              ovf_evt,
  output logic              ovf_flag,
  output logic              armed
);

  localparam int OFF_W = CNT_W - 1;

  logic [CNT_W-1:0] len, sum, dec, diff;
  logic [OFF_W-1:0] mask, off_eff;
  logic             wr, full;

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [OFF_W-1:0] off_q, off_n;
  logic             armed_q, armed_n;
  logic             ovf_q, ovf_n;

  assign len     = CNT_W'(ring_len(loop_code));
  assign mask    = OFF_W'(len - 1'b1);
  assign off_eff = off_q & mask;
  assign wr      = byte_stb && armed_q && en_dma;
  assign full    = (cnt_q >= len);
  assign ovf_evt = wr && full;
  assign sum     = cnt_q + CNT_W'(wr && !full);
  assign dec     = rel_stb ? CNT_W'(rel_val) : '0;
  assign diff    = (dec > sum) ? '0 : (sum - dec);

  always_comb begin
    armed_n = armed_q;
    cnt_n   = (diff > len) ? len : diff;
    off_n   = off_q;
    ovf_n   = ovf_q || ovf_evt;
    if (wr) off_n = (off_eff + 1'b1) & mask;
    if (!en_dma) armed_n = 1'b0;
    else if (kick) armed_n = 1'b1;
    if (kick) begin
      cnt_n = '0;
      off_n = '0;
      ovf_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      off_q   <= '0;
      armed_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      off_q   <= off_n;
      armed_q <= armed_n;
      ovf_q   <= ovf_n;
    end
  end

  assign ram_we    = wr;
  assign ram_addr  = base + ADDR_W'(off_eff);
  assign ram_wdata = byte_in;
  assign count     = cnt_q;
  assign ovf_flag  = ovf_q;
  assign armed     = armed_q;

  // R5: with an unchanged loop code the count never exceeds the ring length
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(loop_code) |-> (cnt_q <= len));

  // R7: a byte into a full ring leaves the count where it was
  a_r7_ovf_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !rel_stb && !kick) |=> (cnt_q == $past(cnt_q)));

  // R7: the overflow flag holds until a kick
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !kick) |=> ovf_q);

  // R9: a kick empties the ring state
  a_r9_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (cnt_q == '0 && !ovf_q && off_q == '0));

endmodule

// File: rtl/uart_rx_ring_dma.sv
module uart_rx_ring_dma
  import urx_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              rxd,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [2:0]        rd_addr,
  output logic [7:0]        rd_data,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic              irq_rx,
  output logic              irq_ovf
);

  ctrl_t             ctrl;
  logic [ADDR_W-1:0] base;
  logic              rel_stb, kick_stb;
  logic [7:0]        rel_val;
  logic              done, bit9, frame_err;
  logic [7:0]        rx_byte;
  logic [CNT_W-1:0]  count;
  logic              ovf_evt, ovf_flag, armed;
  logic [7:0]        status;

  assign status = {4'b0000, armed, ovf_flag, bit9, frame_err};

  urx_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .cnt(count), .last_byte(rx_byte), .status(status),
    .ctrl(ctrl), .base(base),
    .rel_stb(rel_stb), .rel_val(rel_val), .kick_stb(kick_stb)
  );

  urx_deser #(.DW(8)) u_deser (
    .clk(clk), .rst_n(rst_n),
    .en(ctrl.enable), .tick(baud_tick), .rxd(rxd), .ninth_en(ctrl.ninth_en),
    .done(done), .data(rx_byte), .bit9(bit9), .frame_err(frame_err)
  );

  urx_ring #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ring (
    .clk(clk), .rst_n(rst_n),
    .en_dma(ctrl.enable && ctrl.ring_mode), .kick(kick_stb),
    .byte_stb(done), .byte_in(rx_byte), .loop_code(ctrl.loop_code),
    .base(base), .rel_stb(rel_stb), .rel_val(rel_val),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .count(count), .ovf_evt(ovf_evt), .ovf_flag(ovf_flag), .armed(armed)
  );

  assign irq_rx  = done && ctrl.rx_ie;
  assign irq_ovf = ovf_evt && ctrl.ovf_ie;

  // R10: nothing reaches RAM while ring mode is off
  a_r10_no_ram_direct: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.ring_mode |-> !ram_we);

  // R7: an overflow interrupt always accompanies a RAM write
  a_r7_ovf_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ovf |-> ram_we);

endmodule

// File: tb/uart_rx_ring_dma_test.sv
module uart_rx_ring_dma_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        baud_tick = 1'b0;
  logic        rxd = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        ram_we;
  logic [15:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic        irq_rx, irq_ovf;

  int checks = 0;
  int errors = 0;

  logic        g_we, g_irx, g_iovf;
  logic [15:0] g_addr;
  logic [7:0]  g_data;
  logic [7:0]  rv;

  always #4 clk = ~clk;

  uart_rx_ring_dma uut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .irq_rx(irq_rx), .irq_ovf(irq_ovf)
  );

  // {data, stop bit, expected framing error}
  localparam logic [9:0] VEC [8] = '{
    {8'hA5, 1'b1, 1'b0}, {8'h3C, 1'b1, 1'b0}, {8'h00, 1'b0, 1'b1},
    {8'hFF, 1'b1, 1'b0}, {8'h81, 1'b0, 1'b1}, {8'h7E, 1'b1, 1'b0},
    {8'h01, 1'b1, 1'b0}, {8'h80, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_bit(input logic b);
    rxd = b;
    repeat (2) @(negedge clk);
    baud_tick = 1'b1;
    @(negedge clk);
    baud_tick = 1'b0;
  endtask

  // returns at the negedge where the completed byte is visible
  task automatic send_frame(input logic [8:0] d, input logic nine,
                            input logic stopb, input logic [7:0] rel);
    put_bit(1'b0);
    for (int i = 0; i < 8; i++) put_bit(d[i]);
    if (nine) put_bit(d[8]);
    put_bit(stopb);
    g_we = ram_we; g_addr = ram_addr; g_data = ram_wdata;
    g_irx = irq_rx; g_iovf = irq_ovf;
    if (rel != 8'h00) begin
      wr_en = 1'b1; wr_addr = 3'd3; wr_data = rel;
    end
    @(negedge clk);
    wr_en = 1'b0;
    rxd = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic check_count(input string req, input int exp);
    logic [7:0] h, l;
    rd(3'd4, h);
    rd(3'd5, l);
    check(req, {h, l}, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_count("R1 count", 0);
    rd(3'd6, rv); check("R1 status", rv, 8'h00);
    check("R1 outputs", {ram_we, irq_rx, irq_ovf}, 3'b000);

    // ctrl: ovf_ie|rx_ie|code 000|ring|enable = C3
    wr(3'd0, 8'hC3);
    wr(3'd1, 8'h12);
    wr(3'd2, 8'h30);
    wr(3'd4, 8'h00);
    rd(3'd6, rv); check("R9 armed", rv[3], 1'b1);

    for (int i = 0; i < 8; i++) begin
      send_frame({1'b0, VEC[i][9:2]}, 1'b0, VEC[i][1], 8'h00);
      check("R4 addr", g_addr, 16'h1230 + i);
      check("R2 data", {g_we, g_data}, {1'b1, VEC[i][9:2]});
      check("R10 irq_rx", g_irx, 1'b1);
      rd(3'd6, rv); check("R3 frame err", rv[0], VEC[i][0]);
      rd(3'd3, rv); check("R2 last byte", rv, VEC[i][9:2]);
    end
    check_count("R5 count after 8", 8);

    wr(3'd3, 8'd3);
    check_count("R6 release", 5);

    // release lands in the same cycle as a byte: 5+1-2
    send_frame(9'h044, 1'b0, 1'b1, 8'd2);
    check("R4 addr offset 8", g_addr, 16'h1238);
    check_count("R6 same-cycle net", 4);

    // staged high byte must not move the base yet
    wr(3'd1, 8'h40);
    send_frame(9'h055, 1'b0, 1'b1, 8'h00);
    check("R8 base held", g_addr, 16'h1239);
    rd(3'd1, rv); check("R8 staged read", rv, 8'h40);
    wr(3'd2, 8'h00);
    send_frame(9'h066, 1'b0, 1'b1, 8'h00);
    check("R8 base committed", g_addr, 16'h400A);

    for (int i = 0; i < 5; i++) send_frame(9'h070 + i, 1'b0, 1'b1, 8'h00);
    send_frame(9'h099, 1'b0, 1'b1, 8'h00);
    check("R4 wrap to base", g_addr, 16'h4000);
    check_count("R5 count 12", 12);

    for (int i = 0; i < 4; i++) begin
      send_frame(9'h0B0 + i, 1'b0, 1'b1, 8'h00);
      check("R7 no early ovf", g_iovf, 1'b0);
    end
    check_count("R5 full", 16);
    send_frame(9'h0EE, 1'b0, 1'b1, 8'h00);
    check("R7 write on ovf", {g_we, g_addr, g_data}, {1'b1, 16'h4005, 8'hEE});
    check("R7 irq_ovf", g_iovf, 1'b1);
    check_count("R7 count saturates", 16);
    rd(3'd6, rv); check("R7 sticky flag", rv, 8'h0C);

    wr(3'd3, 8'd200);
    check_count("R6 clamp", 0);
    rd(3'd6, rv); check("R7 flag survives release", rv[2], 1'b1);

    wr(3'd4, 8'h00);
    check_count("R9 kick count", 0);
    rd(3'd6, rv); check("R9 kick status", rv, 8'h08);
    send_frame(9'h012, 1'b0, 1'b1, 8'h00);
    check("R9 offset reset", g_addr, 16'h4000);

    // ninth-bit mode
    wr(3'd0, 8'hC7);
    send_frame(9'h1A5, 1'b1, 1'b1, 8'h00);
    check("R2 ninth data", {g_addr, g_data}, {16'h4001, 8'hA5});
    rd(3'd6, rv); check("R2 ninth bit", rv, 8'h0A);
    check_count("R5 count 2", 2);

    // rx interrupt disabled
    wr(3'd0, 8'h83);
    send_frame(9'h021, 1'b0, 1'b1, 8'h00);
    check("R10 irq masked", {g_we, g_irx}, 2'b10);
    check_count("R5 count 3", 3);

    // direct mode: no RAM write, byte still delivered
    wr(3'd0, 8'hC1);
    send_frame(9'h03C, 1'b0, 1'b1, 8'h00);
    check("R10 no ram", {g_we, g_irx}, 2'b01);
    rd(3'd3, rv); check("R10 last byte", rv, 8'h3C);
    check_count("R10 count unchanged", 3);

    // ring mode back on without a kick stays idle
    wr(3'd0, 8'hC3);
    rd(3'd6, rv); check("R11 disarmed", rv[3], 1'b0);
    send_frame(9'h011, 1'b0, 1'b1, 8'h00);
    check("R11 no write", g_we, 1'b0);
    wr(3'd4, 8'h00);
    send_frame(9'h022, 1'b0, 1'b1, 8'h00);
    check("R11 rearmed", {g_we, g_addr}, {1'b1, 16'h4000});

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule